// File: doc/BRIEF.md
# Flash Update Stage Sequencer

This block sits on the device side of a firmware-update link and enforces the order of an update session. Each command arrives as a 12-byte command descriptor block (CDB) on a valid/ready handshake, together with an optional 16-byte parameter block. The block decodes the command, checks it against the current stage of the session, and returns a one-cycle response that carries a status byte and a sense triple (key, additional code, qualifier).

A session must run through these steps in order:
- a vendor unlock;
- a setup command that states the stub contract;
- a fixed number of stub chunk uploads;
- a countdown stream of firmware blocks;
- one status poll;
- ignition.

Only a complete, correctly ordered session produces the single-cycle `ignite` pulse. The end of the stream is reported as a check condition with all-zero sense, which means "ready to burn" and is not an error. Any command that does not fit the current stage is rejected and sends the session back to idle.

Data payloads, checksums, the key exchange and the erase/program engine are handled elsewhere. Image verification reaches the block as a single `image_good` flag that travels with each command.

Top module: `flash_update_sequencer`

## Requirements
- R1: After reset the block is idle. `rsp_valid` and `ignite` are low and `cdb_ready` is high.
- R2: A CDB is accepted on a cycle where `cdb_valid` and `cdb_ready` are both high. Exactly one cycle later `rsp_valid` is high for one cycle, and `cdb_ready` is low in that response cycle.
- R3: The unlock command is accepted only in idle and returns status 0x00 with sense 00/00/00. Its byte 0 (`cdb_bytes[95:88]`) is 0xE7, bytes 1..8 are 48 4C 2D 44 54 2D 53 54, and bytes 9..11 are zero.
- R4: The setup command is accepted only directly after unlock and returns 0x00. Its CDB is 55 10 00 00 00 00 00 00 10 00 00 00. Its parameter block (byte 0 at `cdb_param[127:120]`) must be zero in bytes 0..8 and 12..13, hold 06 48 4C in bytes 9..11, and hold 0F F0 in bytes 14..15. A setup with any other parameter block is rejected.
- R5: After setup, exactly STUB_CHUNKS (default 2) stub commands 55 10 00 00 00 00 00 08 00 00 00 00 are accepted, each returning 0x00. One more stub is rejected.
- R6: Stream blocks have the form 55 10 T 48 4C 07 01 08 00 00 00 00. Tag T (byte 2) must count down from STREAM_BLOCKS-1 to 0. Every block before the last returns 0x00. A block whose tag is out of sequence is rejected.
- R7: The block with tag 0 ends the stream. If `image_good` is high it returns status 0x02 with sense 00/00/00. If `image_good` is low it returns status 0x02 with sense 03/11/00 and the session returns to idle.
- R8: The poll command 5A 10 00 48 4C 08 00 00 12 00 00 00 is accepted only right after a successful stream end, and returns 0x00.
- R9: The ignition command 5A 10 00 48 4C 09 00 00 00 00 00 00 is accepted only right after that poll. It returns 0x00, raises `ignite` for exactly the response cycle, and the session returns to idle.
- R10: Any command that does not fit the current stage returns status 0x02 with sense 05/24/00 and sends the session to idle. A following unlock is then accepted.
- R11: `ignite` is never high except in the response cycle of an accepted ignition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cdb_valid | input | 1 | Command present |
| cdb_ready | output | 1 | Block can take a command |
| cdb_bytes | input | 96 | CDB, byte 0 in bits 95:88 |
| cdb_param | input | 128 | Parameter block, byte 0 in bits 127:120 |
| image_good | input | 1 | Image verification result, sampled with the final stream block |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_status | output | 8 | Status byte |
| rsp_sense | output | 24 | Sense key, additional code, qualifier |
| ignite | output | 1 | One-cycle start pulse for the burn engine |

## Verification
The assertions check on every cycle the timing properties:
- a response follows every accepted command one cycle later and lasts one cycle;
- the stream countdown moves only on an accepted command;
- a rejection always leads to idle;
- `ignite` is a single cycle and always coincides with a good response.

Whether a given command is legal in a given stage can only be shown by the bench's scenarios. These are the full session, a bad image at the stream end, and a sweep that places every command kind in every wrong stage. Single-byte corruptions of the unlock, setup and parameter fields, skipped countdown tags and a repeated ignition are also covered there.

// File: rtl/fus_pkg.sv
package fus_pkg;

    localparam int CDB_BYTES   = 12;
    localparam int PARAM_BYTES = 16;
    localparam int CDB_W       = CDB_BYTES * 8;
    localparam int PARAM_W     = PARAM_BYTES * 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_CONTRACT,
        ST_STREAM,
        ST_ARMED,
        ST_POLLED
    } stage_e;

    typedef enum logic [2:0] {
        K_UNLOCK,
        K_SETUP,
        K_STUB,
        K_BLOCK,
        K_POLL,
        K_IGNITE,
        K_OTHER
    } kind_e;

    typedef enum logic [1:0] {
        RES_GOOD,
        RES_READY,
        RES_REJECT,
        RES_BADIMG
    } result_e;

    typedef struct packed {
        kind_e      kind;
        logic [7:0] tag;
    } cmd_t;

    typedef struct packed {
        logic [7:0] status;
        logic [7:0] key;
        logic [7:0] asc;
        logic [7:0] ascq;
    } reply_t;

    localparam logic [CDB_W-1:0] UNLOCK_PAT  = 96'hE7_48_4C_2D_44_54_2D_53_54_00_00_00;
    localparam logic [CDB_W-1:0] SETUP_PAT   = 96'h55_10_00_00_00_00_00_00_10_00_00_00;
    localparam logic [CDB_W-1:0] STUB_PAT    = 96'h55_10_00_00_00_00_00_08_00_00_00_00;
    localparam logic [CDB_W-1:0] BLOCK_PAT   = 96'h55_10_00_48_4C_07_01_08_00_00_00_00;
    localparam logic [CDB_W-1:0] BLOCK_MASK  = 96'hFF_FF_00_FF_FF_FF_FF_FF_FF_FF_FF_FF;
    localparam logic [CDB_W-1:0] POLL_PAT    = 96'h5A_10_00_48_4C_08_00_00_12_00_00_00;
    localparam logic [CDB_W-1:0] IGNITE_PAT  = 96'h5A_10_00_48_4C_09_00_00_00_00_00_00;
    localparam logic [PARAM_W-1:0] CONTRACT_PAT =
        128'h00_00_00_00_00_00_00_00_00_06_48_4C_00_00_0F_F0;

    localparam int TAG_BYTE = 2;

    function automatic logic [7:0] cdb_byte(input logic [CDB_W-1:0] c, input int idx);
        return c[CDB_W-1-8*idx -: 8];
    endfunction

    function automatic logic [7:0] param_byte(input logic [PARAM_W-1:0] p, input int idx);
        return p[PARAM_W-1-8*idx -: 8];
    endfunction

    function automatic reply_t make_reply(input result_e r);
        reply_t y;
        case (r)
            RES_GOOD:   y = '{status: 8'h00, key: 8'h00, asc: 8'h00, ascq: 8'h00};
            RES_READY:  y = '{status: 8'h02, key: 8'h00, asc: 8'h00, ascq: 8'h00};
            RES_BADIMG: y = '{status: 8'h02, key: 8'h03, asc: 8'h11, ascq: 8'h00};
            default:    y = '{status: 8'h02, key: 8'h05, asc: 8'h24, ascq: 8'h00};
        endcase
        return y;
    endfunction

endpackage

// File: rtl/fus_decode.sv
module fus_decode
    import fus_pkg::*;
(
    input  logic [CDB_W-1:0]   cdb,
    input  logic [PARAM_W-1:0] param,
    output cmd_t               cmd
);

    logic [PARAM_BYTES-1:0] param_hit;
    logic                   contract_ok;

    // Per-byte comparison of the setup parameter block against the contract.
    for (genvar g = 0; g < PARAM_BYTES; g++) begin : g_param
        assign param_hit[g] = (param_byte(param, g) == param_byte(CONTRACT_PAT, g));
    end

    assign contract_ok = &param_hit;

    always_comb begin
        cmd.tag = cdb_byte(cdb, TAG_BYTE);
        if (cdb == UNLOCK_PAT)
            cmd.kind = K_UNLOCK;
        else if (cdb == SETUP_PAT)
            cmd.kind = contract_ok ? K_SETUP : K_OTHER;
        else if (cdb == STUB_PAT)
            cmd.kind = K_STUB;
        else if ((cdb & BLOCK_MASK) == BLOCK_PAT)
            cmd.kind = K_BLOCK;
        else if (cdb == POLL_PAT)
            cmd.kind = K_POLL;
        else if (cdb == IGNITE_PAT)
            cmd.kind = K_IGNITE;
        else
            cmd.kind = K_OTHER;
    end

endmodule

// File: rtl/fus_stage_ctrl.sv
module fus_stage_ctrl
    import fus_pkg::*;
#(
    parameter int STUB_CHUNKS   = 2,
    parameter int STREAM_BLOCKS = 256
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    accept,
    input  cmd_t    cmd,
    input  logic    image_good,
    output result_e res,
    output logic    fire
);

    localparam int         STUB_W    = $clog2(STUB_CHUNKS + 1);
    localparam logic [7:0] FIRST_TAG = 8'(STREAM_BLOCKS - 1);
    localparam logic [STUB_W-1:0] LAST_STUB = STUB_W'(STUB_CHUNKS - 1);

    stage_e            stage_q, stage_d;
    logic [7:0]        tag_q, tag_d;
    logic [STUB_W-1:0] stub_q, stub_d;

    always_comb begin
        stage_d = stage_q;
        tag_d   = tag_q;
        stub_d  = stub_q;
        res     = RES_REJECT;
        fire    = 1'b0;
        case (stage_q)
            ST_IDLE: if (cmd.kind == K_UNLOCK) begin
                res     = RES_GOOD;
                stage_d = ST_OPEN;
            end
            ST_OPEN: if (cmd.kind == K_SETUP) begin
                res     = RES_GOOD;
                stage_d = ST_CONTRACT;
                stub_d  = '0;
            end
            ST_CONTRACT: if (cmd.kind == K_STUB) begin
                res = RES_GOOD;
                if (stub_q == LAST_STUB) begin
                    stage_d = ST_STREAM;
                    tag_d   = FIRST_TAG;
                end else begin
                    stub_d = stub_q + 1'b1;
                end
            end
            ST_STREAM: if (cmd.kind == K_BLOCK && cmd.tag == tag_q) begin
                if (tag_q != 8'd0) begin
                    res   = RES_GOOD;
                    tag_d = tag_q - 8'd1;
                end else if (image_good) begin
                    res     = RES_READY;
                    stage_d = ST_ARMED;
                end else begin
                    res     = RES_BADIMG;
                    stage_d = ST_IDLE;
                end
            end
            ST_ARMED: if (cmd.kind == K_POLL) begin
                res     = RES_GOOD;
                stage_d = ST_POLLED;
            end
            ST_POLLED: if (cmd.kind == K_IGNITE) begin
                res     = RES_GOOD;
                fire    = 1'b1;
                stage_d = ST_IDLE;
            end
            default: ;
        endcase
        if (res == RES_REJECT)
            stage_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= ST_IDLE;
            tag_q   <= '0;
            stub_q  <= '0;
        end else if (accept) begin
            stage_q <= stage_d;
            tag_q   <= tag_d;
            stub_q  <= stub_d;
        end
    end

    assert_reject_to_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (accept && res == RES_REJECT) |=> stage_q == ST_IDLE);

    assert_countdown_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(tag_q) && $stable(stage_q));

    assert_fire_from_polled_R9: assert property (@(posedge clk) disable iff (rst)
        (accept && fire) |=> stage_q == ST_IDLE);

endmodule

// File: rtl/fus_resp.sv
module fus_resp
    import fus_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    accept,
    input  result_e res,
    input  logic    fire,
    output logic    rsp_valid,
    output reply_t  reply,
    output logic    ignite
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            reply     <= '0;
            ignite    <= 1'b0;
        end else begin
            rsp_valid <= accept;
            ignite    <= accept && fire;
            if (accept)
                reply <= make_reply(res);
        end
    end

    assert_ignite_single_R9: assert property (@(posedge clk) disable iff (rst)
        ignite |=> !ignite);

    assert_ignite_good_R11: assert property (@(posedge clk) disable iff (rst)
        ignite |-> rsp_valid && reply.status == 8'h00);

endmodule

// File: rtl/flash_update_sequencer.sv
module flash_update_sequencer
    import fus_pkg::*;
#(
    parameter int STUB_CHUNKS   = 2,
    parameter int STREAM_BLOCKS = 256
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cdb_valid,
    output logic         cdb_ready,
    input  logic [95:0]  cdb_bytes,
    input  logic [127:0] cdb_param,
    input  logic         image_good,
    output logic         rsp_valid,
    output logic [7:0]   rsp_status,
    output logic [23:0]  rsp_sense,
    output logic         ignite
);

    logic    accept;
    cmd_t    cmd;
    result_e res;
    logic    fire;
    reply_t  reply;

    assign cdb_ready = !rsp_valid;
    assign accept    = cdb_valid && cdb_ready;

    fus_decode u_decode (
        .cdb   (cdb_bytes),
        .param (cdb_param),
        .cmd   (cmd)
    );

    fus_stage_ctrl #(
        .STUB_CHUNKS   (STUB_CHUNKS),
        .STREAM_BLOCKS (STREAM_BLOCKS)
    ) u_stage (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .cmd        (cmd),
        .image_good (image_good),
        .res        (res),
        .fire       (fire)
    );

    fus_resp u_resp (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .res       (res),
        .fire      (fire),
        .rsp_valid (rsp_valid),
        .reply     (reply),
        .ignite    (ignite)
    );

    assign rsp_status = reply.status;
    assign rsp_sense  = {reply.key, reply.asc, reply.ascq};

    assert_reply_follows_R2: assert property (@(posedge clk) disable iff (rst)
        (cdb_valid && cdb_ready) |=> rsp_valid);

    assert_reply_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

endmodule

// File: tb/flash_update_sequencer_bench.sv
module flash_update_sequencer_bench;

    localparam int NBLK = 256;

    localparam logic [95:0]  C_UNLOCK = 96'hE7_48_4C_2D_44_54_2D_53_54_00_00_00;
    localparam logic [95:0]  C_SETUP  = 96'h55_10_00_00_00_00_00_00_10_00_00_00;
    localparam logic [95:0]  C_STUB   = 96'h55_10_00_00_00_00_00_08_00_00_00_00;
    localparam logic [95:0]  C_BLOCK  = 96'h55_10_00_48_4C_07_01_08_00_00_00_00;
    localparam logic [95:0]  C_POLL   = 96'h5A_10_00_48_4C_08_00_00_12_00_00_00;
    localparam logic [95:0]  C_IGN    = 96'h5A_10_00_48_4C_09_00_00_00_00_00_00;
    localparam logic [127:0] P_GOOD   = 128'h00_00_00_00_00_00_00_00_00_06_48_4C_00_00_0F_F0;

    localparam logic [23:0] S_NONE = 24'h000000;
    localparam logic [23:0] S_REJ  = 24'h052400;
    localparam logic [23:0] S_BAD  = 24'h031100;

    logic         clk = 1'b0;
    logic         rst;
    logic         cdb_valid;
    logic         cdb_ready;
    logic [95:0]  cdb_bytes;
    logic [127:0] cdb_param;
    logic         image_good;
    logic         rsp_valid;
    logic [7:0]   rsp_status;
    logic [23:0]  rsp_sense;
    logic         ignite;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    flash_update_sequencer u_flash_update_sequencer (
        .clk        (clk),
        .rst        (rst),
        .cdb_valid  (cdb_valid),
        .cdb_ready  (cdb_ready),
        .cdb_bytes  (cdb_bytes),
        .cdb_param  (cdb_param),
        .image_good (image_good),
        .rsp_valid  (rsp_valid),
        .rsp_status (rsp_status),
        .rsp_sense  (rsp_sense),
        .ignite     (ignite)
    );

    function automatic logic [95:0] blk(input logic [7:0] t);
        return C_BLOCK | ({88'd0, t} << 72);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cdb_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic cmd(input logic [95:0] c, input logic [127:0] p, input logic good,
                       input logic [7:0] es, input logic [23:0] ex, input logic eign,
                       input string req);
        @(negedge clk);
        while (!cdb_ready) @(negedge clk);
        cdb_valid = 1'b1; cdb_bytes = c; cdb_param = p; image_good = good;
        @(negedge clk);
        cdb_valid = 1'b0;
        check(rsp_valid && !cdb_ready && rsp_status == es && rsp_sense == ex && ignite == eign,
              req, "response {valid,ready,status,sense,ignite}",
              {29'd0, rsp_valid, cdb_ready, rsp_status, rsp_sense, ignite},
              {29'd0, 1'b1, 1'b0, es, ex, eign});
        @(negedge clk);
        check(!rsp_valid && !ignite && cdb_ready, "R2", "response lasts one cycle",
              {61'd0, rsp_valid, ignite, cdb_ready}, 64'd1);
    endtask

    // Bring the session to stage k: 0 idle, 1 unlocked, 2 contract, 3 stream, 4 armed, 5 polled.
    task automatic advance(input int k);
        do_reset();
        if (k >= 1) cmd(C_UNLOCK, '0, 1'b1, 8'h00, S_NONE, 1'b0, "R3");
        if (k >= 2) cmd(C_SETUP, P_GOOD, 1'b1, 8'h00, S_NONE, 1'b0, "R4");
        if (k >= 3) for (int s = 0; s < 2; s++) cmd(C_STUB, '0, 1'b1, 8'h00, S_NONE, 1'b0, "R5");
        if (k >= 4) begin
            for (int t = NBLK - 1; t > 0; t--) cmd(blk(8'(t)), '0, 1'b1, 8'h00, S_NONE, 1'b0, "R6");
            cmd(blk(8'h00), '0, 1'b1, 8'h02, S_NONE, 1'b0, "R7");
        end
        if (k >= 5) cmd(C_POLL, '0, 1'b1, 8'h00, S_NONE, 1'b0, "R8");
    endtask

    function automatic logic [95:0] kind_cdb(input int j);
        case (j)
            0: return C_UNLOCK;
            1: return C_SETUP;
            2: return C_STUB;
            3: return blk(8'hFF);
            4: return C_POLL;
            default: return C_IGN;
        endcase
    endfunction

    initial begin
        rst = 1'b1; cdb_valid = 1'b0; cdb_bytes = '0; cdb_param = '0; image_good = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!rsp_valid && !ignite && cdb_ready, "R1", "reset outputs",
              {61'd0, rsp_valid, ignite, cdb_ready}, 64'd1);
        rst = 1'b0;
        @(negedge clk);
        check(!rsp_valid && !ignite && cdb_ready, "R1", "idle after reset",
              {61'd0, rsp_valid, ignite, cdb_ready}, 64'd1);

        // R9: full session ending in ignition, then ignition again is rejected (R10, R11)
        advance(5);
        cmd(C_IGN, '0, 1'b1, 8'h00, S_NONE, 1'b1, "R9");
        cmd(C_IGN, '0, 1'b1, 8'h02, S_REJ, 1'b0, "R10");
        cmd(C_UNLOCK, '0, 1'b1, 8'h00, S_NONE, 1'b0, "R10");

        // R7: failed image at stream end goes to idle; poll then rejected
        advance(3);
        for (int t = NBLK - 1; t > 0; t--) cmd(blk(8'(t)), '0, 1'b0, 8'h00, S_NONE, 1'b0, "R6");
        cmd(blk(8'h00), '0, 1'b0, 8'h02, S_BAD, 1'b0, "R7");
        cmd(C_POLL, '0, 1'b1, 8'h02, S_REJ, 1'b0, "R8");

        // R10 sweep: every command kind in every stage where it does not belong
        for (int k = 0; k < 6; k++) begin
            for (int j = 0; j < 6; j++) begin
                if (j != k) begin
                    advance(k);
                    cmd(kind_cdb(j), (j == 1) ? P_GOOD : '0, 1'b1, 8'h02, S_REJ, 1'b0, "R10");
                    cmd(C_UNLOCK, '0, 1'b1, 8'h00, S_NONE, 1'b0, "R10");
                end
            end
        end

        // R3: single-byte corruption of the unlock command
        for (int i = 1; i < 12; i++) begin
            do_reset();
            cmd(C_UNLOCK ^ ({88'd0, 8'h01} << (8 * (11 - i))), '0, 1'b1, 8'h02, S_REJ, 1'b0, "R3");
        end

        // R4: single-byte corruption of the parameter block and of the setup CDB
        for (int i = 0; i < 16; i++) begin
            advance(1);
            cmd(C_SETUP, P_GOOD ^ ({120'd0, 8'h01} << (8 * (15 - i))), 1'b1, 8'h02, S_REJ, 1'b0, "R4");
        end
        for (int i = 2; i < 12; i++) begin
            advance(1);
            cmd(C_SETUP ^ ({88'd0, 8'h40} << (8 * (11 - i))), P_GOOD, 1'b1, 8'h02, S_REJ, 1'b0, "R4");
        end

        // R5: a third stub is rejected
        advance(3);
        cmd(C_STUB, '0, 1'b1, 8'h02, S_REJ, 1'b0, "R5");

        // R6: wrong first tag, and a skipped tag mid-stream
        advance(3);
        cmd(blk(8'hFE), '0, 1'b1, 8'h02, S_REJ, 1'b0, "R6");
        advance(3);
        cmd(blk(8'hFF), '0, 1'b1, 8'h00, S_NONE, 1'b0, "R6");
        cmd(blk(8'hFD), '0, 1'b1, 8'h02, S_REJ, 1'b0, "R6");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule